// File: doc/BRIEF.md
# RGB Sliding Window Generator

This block sits in front of a convolution datapath. It takes a raster-ordered image as a stream of single bytes. Each pixel arrives as three bytes: red, then green, then blue. For every pixel location it produces a square neighbourhood in all three colour channels, 7 by 7 by default. Each output window is a one-cycle strobe carrying all window bytes at once, plus the row and column of the pixel at its centre.

The previous six image lines are held in on-chip line RAM. The current line comes straight from the stream. The output geometry matches the input geometry, so positions that fall outside the image are presented as zero. Nothing is emitted until three rows and three columns past a centre have arrived.

Once the last input pixel has been committed, the block finishes the bottom border rows by itself. It then raises a frame-done strobe together with the window centred on the last pixel. After that it waits for the next frame. The image size and window size are parameters.

Top module: `rgb_window_gen`

## Requirements
- R1: Input bytes are taken in the order red, green, blue for each pixel. In `win_pixels`, the byte for offset (dy, dx) from the centre (each from -3 to +3) and channel ch (0 red, 1 green, 2 blue) sits at bits [8i+7:8i], where i = ((dy+3)*7 + (dx+3))*3 + ch.
- R2: `in_ready` is high, with two exceptions. It is low for one cycle after the third byte of each pixel is accepted, while that pixel is committed. It is also low during the border steps that follow the last pixel of each row and the last row of the frame.
- R3: A byte offered while `in_ready` is low is not taken and has no effect on any later window.
- R4: No window is emitted before the pixel at row 3, column 3 has been committed. The window centred on (0,0) appears on the second clock edge after that pixel's blue byte is accepted.
- R5: Each frame yields exactly IMG_W*IMG_H windows, in raster order. `win_row` and `win_col` give the centre position.
- R6: Window positions outside the image read as zero.
- R7: Window positions inside the image hold the byte received for that row, column and channel.
- R8: `frame_done` is high for one cycle, in the same cycle as the window centred on (IMG_H-1, IMG_W-1), and at no other time.
- R9: After `frame_done`, the next byte starts a new frame at position (0,0), and no pixel of the previous frame shows up in its windows.
- R10: A line RAM is never read and written at the same address in the same cycle. The old line value is read in an earlier cycle, before the commit overwrites it.
- R11: `win_valid` never stays high for two consecutive cycles, and it stays low while no input arrives and no border step is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel byte is offered |
| in_byte | input | 8 | Offered byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| win_valid | output | 1 | One-cycle window strobe |
| win_pixels | output | WIN*WIN*24 (1176) | All window bytes, layout per R1 |
| win_row | output | clog2(IMG_H) (9) | Centre row of the window |
| win_col | output | clog2(IMG_W) (9) | Centre column of the window |
| frame_done | output | 1 | Final window of the frame |

## Verification
Two things share one cycle. On every commit, the line RAMs shift each stored line down by one. In that same cycle, the window register takes in the old values of those lines, which were read earlier. Driving pixels back to back exercises this: any read-and-write clash or wrong stage order would put a neighbouring row into the window. The full content comparison catches that on interior windows. Frame completion also coincides with the last window. This is judged by requiring `frame_done` in exactly the strobe whose centre is the bottom-right pixel. A second frame is then started, with idle gaps and junk bytes offered while `in_ready` is low.

// File: rtl/wg_pkg.sv
package wg_pkg;

    // One pixel, red in the lowest byte so channel c sits at bits [8c+:8].
    typedef struct packed {
        logic [7:0] b;
        logic [7:0] g;
        logic [7:0] r;
    } rgb_t;

    typedef enum logic [1:0] {
        ST_TAKE   = 2'd0,   // collecting bytes of a pixel
        ST_COMMIT = 2'd1,   // pixel complete, column step with RAM write
        ST_PAD_RD = 2'd2,   // border step, read phase
        ST_PAD_WR = 2'd3    // border step, column step phase
    } scan_st_e;

    // LSB of the window slot at window row r, window column c.
    function automatic int slot_lsb(input int win, input int r, input int c);
        return (r * win + c) * $bits(rgb_t);
    endfunction

endpackage

// File: rtl/wg_line_ram.sv
module wg_line_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    // R10: old contents are fetched before the overwrite, never in the same cycle
    a_r10_no_same_addr: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en && rd_addr == wr_addr));

endmodule

// File: rtl/wg_scan_ctrl.sv
module wg_scan_ctrl import wg_pkg::*; #(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512,
    parameter int WIN   = 7,
    localparam int HALF = WIN / 2,
    localparam int XW   = $clog2(IMG_W + HALF),
    localparam int YW   = $clog2(IMG_H + HALF),
    localparam int AW   = $clog2(IMG_W),
    localparam int RW   = $clog2(IMG_H),
    localparam int CW   = $clog2(IMG_W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [7:0]     in_byte,
    output logic           in_ready,
    output logic           step,
    output rgb_t           step_px,
    output logic           ram_re,
    output logic           ram_we,
    output logic [AW-1:0]  ram_addr,
    output logic [WIN-1:0] row_ok,
    output logic           col_ok,
    output logic           emit_ok,
    output logic           last,
    output logic [RW-1:0]  cen_row,
    output logic [CW-1:0]  cen_col
);

    localparam logic [XW-1:0] X_LAST  = XW'(IMG_W + HALF - 1);
    localparam logic [YW-1:0] Y_LAST  = YW'(IMG_H + HALF - 1);
    localparam logic [XW-1:0] X_IMG   = XW'(IMG_W);
    localparam logic [XW-1:0] X_IMG_L = XW'(IMG_W - 1);
    localparam logic [YW-1:0] Y_IMG   = YW'(IMG_H);
    localparam logic [YW-1:0] Y_IMG_L = YW'(IMG_H - 1);

    scan_st_e       st;
    logic [XW-1:0]  sx;
    logic [YW-1:0]  sy;
    logic [1:0]     lane;
    rgb_t           px;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_TAKE;
            sx   <= '0;
            sy   <= '0;
            lane <= '0;
            px   <= '0;
        end else begin
            case (st)
                ST_TAKE: begin
                    if (in_valid) begin
                        case (lane)
                            2'd0:    px.r <= in_byte;
                            2'd1:    px.g <= in_byte;
                            default: px.b <= in_byte;
                        endcase
                        if (lane == 2'd2) begin
                            lane <= '0;
                            st   <= ST_COMMIT;
                        end else begin
                            lane <= lane + 2'd1;
                        end
                    end
                end
                ST_PAD_RD: st <= ST_PAD_WR;
                default: begin
                    // a column step: advance the scan position
                    if (sx == X_LAST) begin
                        sx <= '0;
                        if (sy == Y_LAST) begin
                            sy <= '0;
                            st <= ST_TAKE;
                        end else begin
                            sy <= sy + 1'b1;
                            st <= (sy < Y_IMG_L) ? ST_TAKE : ST_PAD_RD;
                        end
                    end else begin
                        sx <= sx + 1'b1;
                        st <= (sy < Y_IMG && sx < X_IMG_L) ? ST_TAKE : ST_PAD_RD;
                    end
                end
            endcase
        end
    end

    assign in_ready = (st == ST_TAKE);
    assign step     = (st == ST_COMMIT) || (st == ST_PAD_WR);
    assign step_px  = (st == ST_COMMIT) ? px : '0;
    assign col_ok   = (sx < X_IMG);
    assign ram_re   = (st == ST_TAKE) || (st == ST_PAD_RD && col_ok);
    assign ram_we   = step && col_ok;
    assign ram_addr = AW'(sx);
    assign emit_ok  = (sx >= XW'(HALF)) && (sy >= YW'(HALF));
    assign last     = (sx == X_LAST) && (sy == Y_LAST);
    assign cen_row  = RW'(sy - YW'(HALF));
    assign cen_col  = CW'(sx - XW'(HALF));

    // Row sy-k of the column being shifted in lies inside the image.
    always_comb begin
        for (int k = 0; k < WIN; k++) begin
            row_ok[k] = (int'(sy) >= k) && (int'(sy) - k < IMG_H);
        end
    end

    // R2: ready only drops right after the third byte of a pixel was taken
    a_r2_ready_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(in_valid) && $past(lane) == 2'd2);

    // R3: a byte offered while not ready leaves the pixel assembly untouched
    a_r3_stall_ignored: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && in_valid) |=> $stable(px) && lane == 2'd0);

endmodule

// File: rtl/wg_window_regs.sv
module wg_window_regs import wg_pkg::*; #(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512,
    parameter int WIN   = 7,
    localparam int PXW  = $bits(rgb_t),
    localparam int COLW = WIN * PXW,
    localparam int RW   = $clog2(IMG_H),
    localparam int CW   = $clog2(IMG_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic [COLW-1:0]     new_col,
    input  logic                emit_ok,
    input  logic                last,
    input  logic [RW-1:0]       cen_row,
    input  logic [CW-1:0]       cen_col,
    output logic                win_valid,
    output logic [WIN*COLW-1:0] win_flat,
    output logic [RW-1:0]       win_row,
    output logic [CW-1:0]       win_col,
    output logic                frame_done
);

    // cols[0] is the newest (rightmost) column; slot k of a column is row sy-k.
    logic [COLW-1:0] cols [WIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < WIN; c++) cols[c] <= '0;
            win_valid  <= 1'b0;
            frame_done <= 1'b0;
            win_row    <= '0;
            win_col    <= '0;
        end else begin
            win_valid  <= step && emit_ok;
            frame_done <= step && last;
            if (step) begin
                cols[0] <= new_col;
                for (int c = 1; c < WIN; c++) cols[c] <= cols[c-1];
                win_row <= cen_row;
                win_col <= cen_col;
            end
        end
    end

    for (genvar c = 0; c < WIN; c++) begin : g_col
        for (genvar k = 0; k < WIN; k++) begin : g_row
            assign win_flat[slot_lsb(WIN, WIN-1-k, WIN-1-c) +: PXW] = cols[c][k*PXW +: PXW];
        end
    end

    // R8: completion coincides with the bottom-right window only
    a_r8_done_last: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> win_valid && win_row == RW'(IMG_H-1) && win_col == CW'(IMG_W-1));

    // R11: strobes are isolated
    a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        win_valid |=> !win_valid);

    // R5: centre coordinates stay within the image
    a_r5_centre_in_image: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (int'(win_row) < IMG_H) && (int'(win_col) < IMG_W));

endmodule

// File: rtl/rgb_window_gen.sv
module rgb_window_gen import wg_pkg::*; #(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512,
    parameter int WIN   = 7,
    localparam int LINES = WIN - 1,
    localparam int PXW   = $bits(rgb_t),
    localparam int COLW  = WIN * PXW,
    localparam int AW    = $clog2(IMG_W),
    localparam int RW    = $clog2(IMG_H),
    localparam int CW    = $clog2(IMG_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_byte,
    output logic                in_ready,
    output logic                win_valid,
    output logic [WIN*COLW-1:0] win_pixels,
    output logic [RW-1:0]       win_row,
    output logic [CW-1:0]       win_col,
    output logic                frame_done
);

    logic           step, ram_re, ram_we, col_ok, emit_ok, last;
    rgb_t           step_px;
    logic [AW-1:0]  ram_addr;
    logic [WIN-1:0] row_ok;
    logic [RW-1:0]  cen_row;
    logic [CW-1:0]  cen_col;
    rgb_t           rd_px [LINES];
    logic [COLW-1:0] new_col;

    wg_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .WIN(WIN)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_ready (in_ready),
        .step     (step),
        .step_px  (step_px),
        .ram_re   (ram_re),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .row_ok   (row_ok),
        .col_ok   (col_ok),
        .emit_ok  (emit_ok),
        .last     (last),
        .cen_row  (cen_row),
        .cen_col  (cen_col)
    );

    // Line store: line j holds row sy-1-j; a commit shifts every line down one.
    for (genvar j = 0; j < LINES; j++) begin : g_line
        rgb_t wr_px;
        if (j == 0) begin : g_head
            assign wr_px = step_px;
        end else begin : g_tail
            assign wr_px = rd_px[j-1];
        end
        wg_line_ram #(.DEPTH(IMG_W), .WIDTH(PXW)) u_ram (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (ram_re),
            .rd_addr (ram_addr),
            .rd_data (rd_px[j]),
            .wr_en   (ram_we),
            .wr_addr (ram_addr),
            .wr_data (wr_px)
        );
    end

    // New window column with border positions forced to zero.
    for (genvar k = 0; k < WIN; k++) begin : g_newcol
        if (k == 0) begin : g_live
            assign new_col[0 +: PXW] = (row_ok[0] && col_ok) ? step_px : '0;
        end else begin : g_stored
            assign new_col[k*PXW +: PXW] = (row_ok[k] && col_ok) ? rd_px[k-1] : '0;
        end
    end

    wg_window_regs #(.IMG_W(IMG_W), .IMG_H(IMG_H), .WIN(WIN)) u_win (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .new_col    (new_col),
        .emit_ok    (emit_ok),
        .last       (last),
        .cen_row    (cen_row),
        .cen_col    (cen_col),
        .win_valid  (win_valid),
        .win_flat   (win_pixels),
        .win_row    (win_row),
        .win_col    (win_col),
        .frame_done (frame_done)
    );

endmodule

// File: tb/test_rgb_window_gen.sv
module test_rgb_window_gen;

    localparam int W     = 10;
    localparam int H     = 8;
    localparam int WIN   = 7;
    localparam int HALF  = WIN / 2;
    localparam int NBITS = WIN * WIN * 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_ready, win_valid, frame_done;
    logic [NBITS-1:0] win_pixels;
    logic [$clog2(H)-1:0] win_row;
    logic [$clog2(W)-1:0] win_col;

    int n_chk = 0, n_fail = 0;
    int px_sent = 0, seed = 0, frame_no = 0;
    int exp_r = 0, exp_c = 0, nwin = 0, ndone = 0, nbad = 0;
    logic prev_v = 1'b0;
    bit poison = 1'b0;

    rgb_window_gen #(.IMG_W(W), .IMG_H(H), .WIN(WIN)) i_rgb_window_gen (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_ready   (in_ready),
        .win_valid  (win_valid),
        .win_pixels (win_pixels),
        .win_row    (win_row),
        .win_col    (win_col),
        .frame_done (frame_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int y, input int x, input int ch, input int sd);
        return 8'((y * W + x) * 3 + ch + 1 + sd);
    endfunction

    // Window monitor: compares every strobe with the model of the requirements.
    always @(negedge clk) begin
        int bad_i;
        logic [7:0] ba, be;
        string tag;
        if (!rst) begin
            if (win_valid) begin
                bad_i = -1; ba = 8'h00; be = 8'h00;
                for (int i = 0; i < WIN; i++) begin
                    for (int j = 0; j < WIN; j++) begin
                        for (int ch = 0; ch < 3; ch++) begin
                            int y, x, p;
                            logic [7:0] e;
                            y = exp_r + i - HALF;
                            x = exp_c + j - HALF;
                            p = (i * WIN + j) * 3 + ch;
                            e = (y < 0 || y >= H || x < 0 || x >= W) ? 8'h00 : pat(y, x, ch, seed);
                            if (win_pixels[p*8 +: 8] !== e && bad_i < 0) begin
                                bad_i = p; ba = win_pixels[p*8 +: 8]; be = e;
                            end
                        end
                    end
                end
                if (frame_no > 0 && exp_r < HALF) tag = "R9";
                else if (exp_r < HALF || exp_c < HALF || exp_r >= H - HALF || exp_c >= W - HALF) tag = "R6";
                else tag = "R1 R7 R10";
                chk(bad_i < 0, tag, "window byte", ba, be);
                if (bad_i >= 0) nbad++;
                chk(int'(win_row) == exp_r && int'(win_col) == exp_c, "R5", "centre row*100+col",
                    int'(win_row) * 100 + int'(win_col), exp_r * 100 + exp_c);
                if (exp_r == 0 && exp_c == 0)
                    chk(px_sent == 3 * W + 4, "R4", "pixels committed at first window", px_sent, 3 * W + 4);
                chk(frame_done == (exp_r == H - 1 && exp_c == W - 1), "R8", "frame_done with window",
                    frame_done, (exp_r == H - 1 && exp_c == W - 1));
                chk(!prev_v, "R11", "strobe isolated", prev_v, 0);
                if (frame_done) begin ndone++; frame_no++; end
                if (exp_c == W - 1) begin
                    exp_c = 0;
                    exp_r = (exp_r == H - 1) ? 0 : exp_r + 1;
                end else begin
                    exp_c++;
                end
                nwin++;
            end else if (frame_done) begin
                chk(1'b0, "R8", "frame_done without window", 1, 0);
            end
            prev_v = win_valid;
        end
    end

    // Called at a negedge; leaves the byte accepted and returns at the next negedge.
    task automatic send_byte(input logic [7:0] b, input int gap, input bit third);
        for (int g = 0; g < gap; g++) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        while (!in_ready) begin
            in_valid = poison;      // R3: junk offered while not ready
            in_byte  = 8'hEE;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        chk(in_ready == !third, "R2", "ready after byte", in_ready, !third);
    endtask

    task automatic send_frame(input int sd, input bit gaps, input bit junk);
        int d0;
        d0 = ndone;
        seed = sd;
        poison = junk;
        px_sent = 0;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                for (int ch = 0; ch < 3; ch++) begin
                    send_byte(pat(y, x, ch, sd), gaps ? (y + x + ch) % 3 : 0, ch == 2);
                    if (ch == 2) px_sent++;
                end
            end
        end
        in_valid = 1'b0;
        poison = 1'b0;
        while (ndone == d0) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1, "R2", "ready after reset", in_ready, 1);
        chk(win_valid == 1'b0, "R11", "no strobe after reset", win_valid, 0);
        chk(frame_done == 1'b0, "R8", "no done after reset", frame_done, 0);
    endtask

    task automatic t_plain_frame;
        int w0, b0;
        w0 = nwin; b0 = nbad;
        send_frame(0, 1'b0, 1'b0);
        chk(nwin - w0 == W * H, "R5", "windows in back-to-back frame", nwin - w0, W * H);
        chk(nbad == b0, "R7", "bad windows in back-to-back frame", nbad - b0, 0);
    endtask

    task automatic t_gappy_junk_frame;
        int w0, b0;
        w0 = nwin; b0 = nbad;
        send_frame(10, 1'b1, 1'b1);
        chk(nwin - w0 == W * H, "R5", "windows in second frame", nwin - w0, W * H);
        chk(nbad == b0, "R3", "bad windows with junk offered", nbad - b0, 0);
        chk(ndone == 2, "R9", "frames completed", ndone, 2);
    endtask

    task automatic t_idle;
        int nv, nr;
        nv = 0; nr = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (win_valid) nv++;
            if (!in_ready) nr++;
        end
        chk(nv == 0, "R11", "strobes while idle", nv, 0);
        chk(nr == 0, "R2", "ready low cycles while idle", nr, 0);
    endtask

    initial begin
        t_reset();
        t_plain_frame();
        t_gappy_junk_frame();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R5 watchdog expired: actual %0d expected %0d", nwin, 2 * W * H);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule